// File: doc/BRIEF.md
# Keyed Watchdog with Sticky Register Locks

This block is an 8-bit down-counting watchdog. It stays idle out of reset and comes alive on the first accepted write to either its count register or its service-key register. From then on it cannot be stopped by anything except reset. The counter steps down on a tick drawn from one of two timer signals: the timer's raw input tick or the tick the timer emits when it reaches zero. A halt input freezes the count where it stands.

Software keeps the watchdog alive in one of two ways. In count mode it writes a fresh count. In key mode it writes the fixed key 0x5C, and the counter reloads from the stored count. The block raises a sticky error level in three cases: the counter is allowed to run past zero, a service arrives before the counter has stepped even once since the last service or start, or a wrong key is written while key mode is on.

A configuration register carries lock bits that can only be set. Each lock bit freezes one register against writes and makes it read as zero. One of the lock bits covers the configuration register itself. The same register file also stores the timer's reload value and control byte, which are driven out to the timer. A power-mode input limits access. In any mode other than active, only the service-key register accepts writes, and every read returns zero.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wd_running`, `wd_err` and `wd_count` are 0. An accepted write to the count register (address 3) or the key register (address 4) sets `wd_running`. Once set, it stays set until reset.
- R2: Configuration bit 0 selects the decrement tick. When it is 0, `tick_in` is used. When it is 1, `tick_zero` is used. The unselected tick has no effect on `wd_count`.
- R3: With configuration bit 1 (key mode) clear, an accepted count write loads the written value into `wd_count`. This applies both at start and while running.
- R4: With key mode set, writing 0x5C to the key register reloads `wd_count` from the stored count register. A count write while running only updates the stored value.
- R5: With key mode set, writing any value other than 0x5C to the key register sets `wd_err`.
- R6: A selected tick that arrives while running with `wd_count` at 0, and with no service in the same cycle, sets `wd_err`.
- R7: A service that arrives before at least one decrement since the previous service or start sets `wd_err`.
- R8: `wd_err` stays at 1 until reset. While it is set, `wd_count` no longer changes.
- R9: Configuration bits 2, 3, 4 and 5 lock, in turn, the configuration register, the timer reload register (address 1), the timer control register (address 2) and the count register. A lock bit, once set, cannot be cleared by a write. A locked register ignores writes and reads as 0.
- R10: When `pwr_mode` is not 0, writes to addresses 0 to 3 are ignored and reads return 0. Key-register writes are still accepted.
- R11: While `halt` is 1, ticks do not change `wd_count`. Counting resumes from the held value once `halt` returns to 0.
- R12: Addresses 0 to 2 read back their stored values when they are unlocked and the mode is active. The key register always reads 0. `timer_reload` and `timer_ctrl` present the contents of addresses 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Timer input tick (one-cycle pulse) |
| tick_zero | input | 1 | Timer zero-reached tick (one-cycle pulse) |
| halt | input | 1 | Freezes counting while high |
| pwr_mode | input | 2 | 0 = active, any other value = low power |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| timer_reload | output | 8 | Stored timer reload value |
| timer_ctrl | output | 8 | Stored timer control byte |
| wd_count | output | 8 | Current watchdog count |
| wd_running | output | 1 | Watchdog has been started |
| wd_err | output | 1 | Sticky watchdog error |

## Verification
Internal state in this block shows up at the ports quickly. A wrong count value appears on `wd_count` one clock after the edge that produced it. A lost or stuck lock bit, or a dropped "stepped since service" flag, stays hidden until the next write or service. At that point `reg_rdata`, `wd_running` or `wd_err` differs within one clock. The bench therefore compares every output against a behavioural model on every cycle, and aims its directed writes right after the state changes that would expose these faults.

// File: rtl/kwd_pkg.sv
// Shared register addresses and configuration bit positions for the keyed watchdog.
// Assumes an 8-bit register file.
package kwd_pkg;
    typedef enum logic [2:0] {
        ADR_CFG  = 3'd0,
        ADR_TRLD = 3'd1,
        ADR_TCTL = 3'd2,
        ADR_CNT  = 3'd3,
        ADR_KEY  = 3'd4
    } kwd_addr_e;

    localparam int CFG_SRC_ZERO = 0;  // tick select
    localparam int CFG_KEY_MODE = 1;  // service style
    localparam int CFG_LK_LO    = 2;  // lock field low bit
    localparam int CFG_LK_HI    = 5;  // lock field high bit
    localparam int NUM_DREGS    = 3;  // reload, control, count
endpackage

// File: rtl/kwd_tick_sel.sv
// Picks the decrement tick from the two timer signals and gates it with halt.
// Assumes both ticks are single-cycle pulses in the clk domain.
module kwd_tick_sel (
    input  logic src_zero,
    input  logic halt,
    input  logic tick_in,
    input  logic tick_zero,
    output logic tick
);
    // Select the tick source, then drop it while halted.
    always_comb begin
        tick = (src_zero ? tick_zero : tick_in) & ~halt;
    end
endmodule

// File: rtl/kwd_regs.sv
// Register file. Holds the configuration register with its set-only lock field,
// plus three data registers. Gates accesses on power mode and locks.
// Assumes one access per cycle; reads are combinational.
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pwr_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              src_zero,
    output logic              key_mode,
    output logic [DATA_W-1:0] trld_q,
    output logic [DATA_W-1:0] tctl_q,
    output logic [DATA_W-1:0] cnt_reg_q,
    output logic              cnt_wr,
    output logic              key_wr
);
    localparam int LK_W = CFG_LK_HI - CFG_LK_LO + 1;

    logic [DATA_W-1:0]           cfg_q;
    logic [NUM_DREGS*DATA_W-1:0] dregs;
    logic [LK_W-1:0]             locks;
    logic                        active;
    logic                        cfg_ok;
    logic [NUM_DREGS-1:0]        dreg_ok;

    assign active = (pwr_mode == 2'd0);
    assign locks  = cfg_q[CFG_LK_HI:CFG_LK_LO];
    assign cfg_ok = wr && active && (addr == ADR_CFG) && !locks[0];

    // Configuration register: lock bits are OR-ed in, reserved bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_ok) begin
            cfg_q <= '0;
            cfg_q[CFG_SRC_ZERO] <= wdata[CFG_SRC_ZERO];
            cfg_q[CFG_KEY_MODE] <= wdata[CFG_KEY_MODE];
            cfg_q[CFG_LK_HI:CFG_LK_LO] <= locks | wdata[CFG_LK_HI:CFG_LK_LO];
        end
    end

    generate
        for (genvar i = 0; i < NUM_DREGS; i++) begin : g_dreg
            localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(int'(ADR_TRLD) + i);
            logic [DATA_W-1:0] val_q;

            assign dreg_ok[i] = wr && active && (addr == MY_ADR) && !locks[i+1];

            // One data register, written only when unlocked and active.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (dreg_ok[i]) begin
                    val_q <= wdata;
                end
            end

            assign dregs[i*DATA_W +: DATA_W] = val_q;
        end
    endgenerate

    assign src_zero  = cfg_q[CFG_SRC_ZERO];
    assign key_mode  = cfg_q[CFG_KEY_MODE];
    assign trld_q    = dregs[0 +: DATA_W];
    assign tctl_q    = dregs[DATA_W +: DATA_W];
    assign cnt_reg_q = dregs[2*DATA_W +: DATA_W];
    assign cnt_wr    = dreg_ok[2];
    assign key_wr    = wr && (addr == ADR_KEY);

    // Read mux: zero in low power, for locked registers and for the key register.
    always_comb begin
        rdata = '0;
        if (active) begin
            case (addr)
                ADR_CFG:  rdata = locks[0] ? '0 : cfg_q;
                ADR_TRLD: rdata = locks[1] ? '0 : trld_q;
                ADR_TCTL: rdata = locks[2] ? '0 : tctl_q;
                ADR_CNT:  rdata = locks[3] ? '0 : cnt_reg_q;
                default:  rdata = '0;
            endcase
        end
    end

    // R9: no lock bit ever drops once set
    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|locks) |=> ((($past(locks)) & ~locks) == '0));

    // R10: in low power, non-key writes leave all registers untouched
    assert_lowpower_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !active && (addr != ADR_KEY)) |=> ($stable(cfg_q) && $stable(dregs)));
endmodule

// File: rtl/kwd_counter.sv
// Watchdog down-counter with start, the two service styles, and sticky error detection.
// Assumes cnt_wr and key_wr are already qualified by locks and power mode.
module kwd_counter #(
    parameter int              CNT_W   = 8,
    parameter logic [CNT_W-1:0] KEY_VAL = 8'h5C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             key_mode,
    input  logic             cnt_wr,
    input  logic             key_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt_reg_q,
    output logic [CNT_W-1:0] count_q,
    output logic             running_q,
    output logic             err_q
);
    logic             stepped_q;
    logic             key_hit, key_bad, svc, start, early, late;
    logic [CNT_W-1:0] load_val;

    // Classify this cycle's writes and ticks.
    always_comb begin
        key_hit  = key_wr && (wdata == KEY_VAL);
        key_bad  = key_wr && key_mode && !key_hit;
        svc      = running_q && (key_mode ? key_hit : cnt_wr);
        start    = !running_q && (cnt_wr || key_wr);
        load_val = cnt_wr ? wdata : cnt_reg_q;
        early    = svc && !stepped_q;
        late     = running_q && tick && !svc && (count_q == '0);
    end

    // Count, reload and latch errors; everything freezes once an error is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            running_q <= 1'b0;
            stepped_q <= 1'b0;
            err_q     <= 1'b0;
        end else if (!err_q) begin
            if (key_bad || early || late) begin
                err_q <= 1'b1;
            end
            if (start || svc) begin
                count_q   <= load_val;
                running_q <= 1'b1;
                stepped_q <= 1'b0;
            end else if (running_q && tick && (count_q != '0)) begin
                count_q   <= count_q - 1'b1;
                stepped_q <= 1'b1;
            end
        end
    end

    // R8: error is sticky
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R6: tick at zero without service gives an error
    assert_late_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && tick && (count_q == '0) && !cnt_wr && !key_wr) |=> err_q);

    // R11: with no tick and no write, the count holds
    assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr && !key_wr) |=> $stable(count_q));

    // R7: service right after start or service gives an error
    assert_early_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !key_mode && cnt_wr && !stepped_q) |=> err_q);
endmodule

// File: rtl/keyed_watchdog.sv
// Top level: register file, tick select and watchdog counter.
// Assumes reg_* accesses are synchronous to clk and the ticks are one-cycle pulses.
module keyed_watchdog #(
    parameter int              DATA_W  = 8,
    parameter int              ADDR_W  = 3,
    parameter logic [DATA_W-1:0] KEY_VAL = 8'h5C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              tick_zero,
    input  logic              halt,
    input  logic [1:0]        pwr_mode,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] timer_reload,
    output logic [DATA_W-1:0] timer_ctrl,
    output logic [DATA_W-1:0] wd_count,
    output logic              wd_running,
    output logic              wd_err
);
    logic              src_zero, key_mode, cnt_wr, key_wr, tick;
    logic [DATA_W-1:0] cnt_reg_q;

    kwd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_mode  (pwr_mode),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .src_zero  (src_zero),
        .key_mode  (key_mode),
        .trld_q    (timer_reload),
        .tctl_q    (timer_ctrl),
        .cnt_reg_q (cnt_reg_q),
        .cnt_wr    (cnt_wr),
        .key_wr    (key_wr)
    );

    kwd_tick_sel u_tick (
        .src_zero  (src_zero),
        .halt      (halt),
        .tick_in   (tick_in),
        .tick_zero (tick_zero),
        .tick      (tick)
    );

    kwd_counter #(.CNT_W(DATA_W), .KEY_VAL(KEY_VAL)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .key_mode  (key_mode),
        .cnt_wr    (cnt_wr),
        .key_wr    (key_wr),
        .wdata     (reg_wdata),
        .cnt_reg_q (cnt_reg_q),
        .count_q   (wd_count),
        .running_q (wd_running),
        .err_q     (wd_err)
    );

    // R1: once started the watchdog never stops
    assert_running_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wd_running |=> wd_running);
endmodule

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
    logic       clk = 0, rst_n = 0;
    logic       tick_in = 0, tick_zero = 0, halt = 0, reg_wr = 0;
    logic [1:0] pwr_mode = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata, timer_reload, timer_ctrl, wd_count;
    logic       wd_running, wd_err;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    keyed_watchdog u0 (.*);

    // Behavioural reference model
    int m_cfg, m_trld, m_tctl, m_creg, m_cnt;
    bit m_run, m_step, m_err;

    function automatic int m_read(int a);
        if (pwr_mode != 0) return 0;
        case (a)
            0: return m_cfg[2]  ? 0 : m_cfg;
            1: return m_cfg[3]  ? 0 : m_trld;
            2: return m_cfg[4]  ? 0 : m_tctl;
            3: return m_cfg[5]  ? 0 : m_creg;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_trld = 0; m_tctl = 0; m_creg = 0;
            m_cnt = 0; m_run = 0; m_step = 0; m_err = 0;
        end else begin
            bit act, kmode, cw, kw, srv, st, tk, bad;
            int nv;
            act   = (pwr_mode == 0);
            kmode = m_cfg[1];
            cw    = reg_wr && act && reg_addr == 3 && !m_cfg[5];
            kw    = reg_wr && reg_addr == 4;
            tk    = (m_cfg[0] ? tick_zero : tick_in) && !halt;
            srv   = m_run && (kmode ? (kw && reg_wdata == 8'h5C) : cw);
            st    = !m_run && (cw || kw);
            nv    = cw ? reg_wdata : m_creg;
            bad   = (kw && kmode && reg_wdata != 8'h5C) || (srv && !m_step)
                    || (m_run && tk && !srv && m_cnt == 0);
            if (!m_err) begin
                if (st || srv) begin m_cnt = nv; m_run = 1; m_step = 0; end
                else if (m_run && tk && m_cnt != 0) begin m_cnt--; m_step = 1; end
                if (bad) m_err = 1;
            end
            if (reg_wr && act) begin
                if (reg_addr == 0 && !m_cfg[2])
                    m_cfg = (m_cfg & 8'h3C) | (reg_wdata & 8'h3F);
                if (reg_addr == 1 && !m_cfg[3]) m_trld = reg_wdata;
                if (reg_addr == 2 && !m_cfg[4]) m_tctl = reg_wdata;
                if (reg_addr == 3 && !m_cfg[5]) m_creg = reg_wdata;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 model count", wd_count, m_cnt);
            check("R1 model running", wd_running, m_run);
            check("R8 model error", wd_err, m_err);
            check("R12 model rdata", reg_rdata, m_read(reg_addr));
            check("R12 model reload", timer_reload, m_trld);
            check("R12 model ctrl", timer_ctrl, m_tctl);
        end
    end

    task automatic do_reset();
        @(negedge clk); #1 rst_n = 0; pwr_mode = 0; halt = 0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
    endtask

    task automatic wr(int a, int d);
        @(negedge clk); #1 reg_addr = 3'(a); reg_wdata = 8'(d); reg_wr = 1;
        @(negedge clk); #1 reg_wr = 0;
    endtask

    task automatic rd(int a, string req, int exp);
        @(negedge clk); #1 reg_addr = 3'(a);
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic pulse(bit zero_src, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1 if (zero_src) tick_zero = 1; else tick_in = 1;
            @(negedge clk); #1 tick_zero = 0; tick_in = 0;
        end
    endtask

    initial begin
        do_reset();
        check("R1 reset running", wd_running, 0);
        check("R1 reset err", wd_err, 0);
        check("R1 reset count", wd_count, 0);
        // R12 data registers
        wr(1, 8'h34); wr(2, 8'hA5);
        rd(1, "R12 reload read", 8'h34);
        rd(2, "R12 ctrl read", 8'hA5);
        rd(4, "R12 key reads zero", 0);
        check("R12 reload out", timer_reload, 8'h34);
        // R1 / R2 / R3 / R7 / R8
        wr(3, 5);
        check("R1 started", wd_running, 1);
        check("R3 start load", wd_count, 5);
        pulse(1, 3);
        check("R2 unselected tick ignored", wd_count, 5);
        pulse(0, 2);
        check("R2 selected tick", wd_count, 3);
        wr(3, 6);
        check("R3 reload", wd_count, 6);
        check("R7 no error after step", wd_err, 0);
        wr(3, 6);
        check("R7 too often", wd_err, 1);
        pulse(0, 2);
        check("R8 sticky", wd_err, 1);
        check("R8 frozen", wd_count, 6);
        check("R1 stays running", wd_running, 1);

        // R4 / R11 / R6
        do_reset();
        wr(0, 8'h03); wr(3, 4);
        pulse(1, 1);
        check("R2 zero source", wd_count, 3);
        wr(4, 8'h5C);
        check("R4 key reload", wd_count, 4);
        wr(3, 9);
        check("R4 count write no reload", wd_count, 4);
        @(negedge clk); #1 halt = 1;
        pulse(1, 3);
        check("R11 halt holds", wd_count, 4);
        @(negedge clk); #1 halt = 0;
        pulse(1, 4);
        check("R11 resumes", wd_count, 0);
        check("R6 not yet late", wd_err, 0);
        pulse(1, 1);
        check("R6 late", wd_err, 1);

        // R5
        do_reset();
        wr(0, 8'h02); wr(3, 9);
        pulse(0, 1);
        wr(4, 8'h11);
        check("R5 wrong key", wd_err, 1);

        // R9
        do_reset();
        wr(0, 8'h28);
        rd(0, "R9 cfg readable", 8'h28);
        wr(1, 8'h77);
        rd(1, "R9 locked reads zero", 0);
        check("R9 locked write ignored", timer_reload, 0);
        wr(0, 8'h00);
        rd(0, "R9 locks sticky", 8'h28);
        wr(0, 8'h04);
        rd(0, "R9 cfg locked reads zero", 0);
        wr(0, 8'h02);
        wr(3, 3);
        check("R9 count locked no start", wd_running, 0);
        wr(4, 8'h11);
        check("R9 started by key", wd_running, 1);
        check("R9 cfg write ignored", wd_err, 0);

        // R10
        do_reset();
        wr(1, 8'h40);
        @(negedge clk); #1 pwr_mode = 2;
        rd(1, "R10 lowpower read zero", 0);
        wr(3, 7);
        check("R10 count write ignored", wd_running, 0);
        wr(0, 8'h02);
        @(negedge clk); #1 pwr_mode = 0;
        rd(0, "R10 cfg write ignored", 0);
        rd(1, "R10 value kept", 8'h40);
        @(negedge clk); #1 pwr_mode = 1;
        wr(4, 8'h5C);
        check("R10 key accepted", wd_running, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog timeout actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule